// File: doc/BRIEF.md
# Word-Packed Serial Port

This block is a 16550-style serial port. Software reaches it over a simple 32-bit register bus on which every register sits at its own word-aligned address. It sends and receives 8N1 characters at 16x oversampling. The bit rate comes from one full-width divisor register. Two small FIFOs buffer the transmit and receive paths, and a status word reports the state of both directions.

Unlike the classic layout, pairs of byte-wide registers share a single word. One word carries the character byte next to the FIFO control byte. Another carries line control next to modem control. The divisor has its own register, so no access-latch bit is needed before it is written. Software polls the status word, writes characters while the holding-empty flag is set, and reads characters while the data-ready flag is set.

Top module: `packed_uart`

## Requirements
- R1: The register index is byte address bits [5:2], so index n sits at byte offset 4n. Index 3 reads back the character byte in bits [15:8] and the FIFO control byte in bits [7:0]. Index 4 reads back line control in bits [15:8] and modem control in bits [7:0]. Index 9 reads back the stored divisor.
- R2: After reset the status word (index 5) reads 0x60, the divisor reads 1, index 3 reads 0, index 4 reads 0x0300, both FIFOs are empty and `tx_o` stays high while no frame is being sent.
- R3: A write to index 0 sends the character as one low start bit, then eight data bits with the LSB first, then one high stop bit. Every bit lasts 16 × divisor clock cycles.
- R4: A divisor value of 0 produces the same bit time as a divisor of 1.
- R5: A new divisor takes effect only at a character boundary. A frame already in progress finishes at its old bit time.
- R6: The receiver starts a frame on a falling edge of `rx_i` and samples each bit on the 8th oversample tick. A received character sets status bit 0. Reading index 0 returns the oldest character and removes it. Status bit 0 clears when the receive FIFO becomes empty.
- R7: A stop bit sampled low sets status bit 3. The character is still stored. Reading the status word clears bit 3.
- R8: Status bit 5 (holding empty) clears in the cycle after a character is queued. Status bit 6 (transmitter empty) is set only when the transmit FIFO and the shifter are both idle.
- R9: FIFO control bit 0 enables both FIFOs at `DEPTH` entries each. With the bit clear, each path holds one character. A write to index 0 while the transmit path is full is dropped.
- R10: A character that completes while the receive path is full is dropped. The characters already held stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | UART and bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects at the clock edge) |
| addr | input | 4 | Byte address bits [5:2], the register index |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the addressed register, combinational |
| rx_i | input | 1 | Serial receive line |
| tx_o | output | 1 | Serial transmit line |

## Verification
On every cycle the assertions check several invariants. The transmit line is high whenever no frame is active. The FIFO counts never exceed their depth. The transmitter-empty flag implies holding-empty. The active divisor is never zero and stays fixed while a frame is being sent. A write into an empty transmit path clears holding-empty in the next cycle. Popping the last received character clears data-ready. Other behaviour can only be shown by the bench scenarios driving the serial lines: exact bit timing and bit order for several divisors, the moment a divisor change takes effect, dropped writes and dropped characters at each FIFO setting, and when the framing-error flag sets and clears.

// File: rtl/packed_uart.sv
module packed_uart #(
  parameter int DEPTH = 4,   // power of two
  parameter int DIV_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [5:2]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        rx_i,
  output logic        tx_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [7:0] fcr, chr, lcr, mcr;
  logic [DIV_W-1:0] div_reg, div_act, div_eff;
  logic [CW-1:0] cap;
  logic unused_bits;
  assign unused_bits = ^wdata[31:16];

  wire wr_tx  = wr_en && addr == 4'd0;
  wire rd_rx  = rd_en && addr == 4'd0;
  wire rd_lsr = rd_en && addr == 4'd5;
  assign cap     = fcr[0] ? CW'(DEPTH) : CW'(1);
  assign div_eff = (div_reg == '0) ? DIV_W'(1) : div_reg;

  // transmit path
  logic [7:0] txm [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp;
  logic [CW-1:0] tx_cnt;
  logic tx_busy;
  logic [9:0] tx_sh;
  logic [3:0] tx_bit, tx_ph;
  logic [DIV_W-1:0] tx_pre;
  wire tx_pop  = !tx_busy && tx_cnt != '0;
  wire tx_push = wr_tx && (tx_cnt < cap || (tx_pop && tx_cnt <= cap));
  wire tx_tick = tx_pre == div_act - DIV_W'(1);

  // receive path
  logic [7:0] rxm [DEPTH];
  logic [AW-1:0] rx_wp, rx_rp;
  logic [CW-1:0] rx_cnt;
  logic rs1, rs2, rs3, rx_busy, fe;
  logic [7:0] rx_sh;
  logic [3:0] rx_bit, rx_ph;
  logic [DIV_W-1:0] rx_pre;
  wire rx_tick = rx_pre == div_act - DIV_W'(1);
  wire rx_samp = rx_busy && rx_tick && rx_ph == 4'd7;
  wire rx_done = rx_samp && rx_bit == 4'd9;
  wire rx_push = rx_done && rx_cnt < cap;
  wire rx_pop  = rd_rx && rx_cnt != '0;

  logic [7:0] lsr;
  assign lsr = {1'b0, !tx_busy && tx_cnt == '0, tx_cnt == '0, 1'b0, fe, 2'b00, rx_cnt != '0};
  assign tx_o = tx_busy ? tx_sh[0] : 1'b1;

  always_comb begin
    case (addr)
      4'd0:    rdata = {24'h0, rxm[rx_rp]};
      4'd3:    rdata = {16'h0, chr, fcr};
      4'd4:    rdata = {16'h0, lcr, mcr};
      4'd5:    rdata = {24'h0, lsr};
      4'd9:    rdata = 32'(div_reg);
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcr <= '0; chr <= '0; lcr <= 8'h03; mcr <= '0;
      div_reg <= DIV_W'(1); div_act <= DIV_W'(1);
    end else begin
      if (wr_en && addr == 4'd3) {chr, fcr} <= wdata[15:0];
      if (wr_en && addr == 4'd4) {lcr, mcr} <= wdata[15:0];
      if (wr_en && addr == 4'd9) div_reg <= wdata[DIV_W-1:0];
      if (!tx_busy && !rx_busy) div_act <= div_eff;
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push) txm[tx_wp] <= wdata[7:0];
    if (rx_push) rxm[rx_wp] <= rx_sh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      tx_busy <= 1'b0; tx_sh <= '1; tx_bit <= '0; tx_ph <= '0; tx_pre <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + AW'(1);
      if (tx_pop)  tx_rp <= tx_rp + AW'(1);
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
      if (tx_pop) begin
        tx_busy <= 1'b1;
        tx_sh   <= {1'b1, txm[tx_rp], 1'b0};
        tx_bit  <= '0; tx_ph <= '0; tx_pre <= '0;
      end else if (tx_busy) begin
        if (tx_tick) begin
          tx_pre <= '0;
          tx_ph  <= tx_ph + 4'd1;
          if (tx_ph == 4'd15) begin
            tx_sh <= {1'b1, tx_sh[9:1]};
            if (tx_bit == 4'd9) tx_busy <= 1'b0;
            else tx_bit <= tx_bit + 4'd1;
          end
        end else tx_pre <= tx_pre + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1 <= 1'b1; rs2 <= 1'b1; rs3 <= 1'b1;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0; fe <= 1'b0;
      rx_busy <= 1'b0; rx_sh <= '0; rx_bit <= '0; rx_ph <= '0; rx_pre <= '0;
    end else begin
      {rs3, rs2, rs1} <= {rs2, rs1, rx_i};
      if (rx_push) rx_wp <= rx_wp + AW'(1);
      if (rx_pop)  rx_rp <= rx_rp + AW'(1);
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
      if (rx_done && !rs2) fe <= 1'b1;
      else if (rd_lsr) fe <= 1'b0;
      if (!rx_busy) begin
        if (rs3 && !rs2) begin
          rx_busy <= 1'b1; rx_bit <= '0; rx_ph <= '0; rx_pre <= '0;
        end
      end else if (rx_tick) begin
        rx_pre <= '0;
        rx_ph  <= rx_ph + 4'd1;
        if (rx_ph == 4'd7) begin
          rx_bit <= rx_bit + 4'd1;
          if (rx_bit == 4'd0 && rs2) rx_busy <= 1'b0;
          else if (rx_bit == 4'd9) rx_busy <= 1'b0;
          else if (rx_bit != 4'd0) rx_sh <= {rs2, rx_sh[7:1]};
        end
      end else rx_pre <= rx_pre + DIV_W'(1);
    end
  end
endmodule

// File: rtl/packed_uart_chk.sv
module packed_uart_chk #(
  parameter int DEPTH = 4,
  parameter int DIV_W = 16,
  parameter int CW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             rd_en,
  input logic [5:2]       addr,
  input logic             tx_o,
  input logic             tx_busy,
  input logic [CW-1:0]    tx_cnt,
  input logic [CW-1:0]    rx_cnt,
  input logic             rx_push,
  input logic [7:0]       lsr,
  input logic [DIV_W-1:0] div_act
);
  a_r2_line_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> tx_o);
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CW'(DEPTH) && rx_cnt <= CW'(DEPTH));
  a_r8_thre_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'd0 && tx_cnt == '0) |=> !lsr[5]);
  a_r8_temt_implies_thre: assert property (@(posedge clk) disable iff (!rst_n)
    lsr[6] |-> lsr[5]);
  a_r5_div_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && $past(tx_busy)) |-> $stable(div_act));
  a_r4_div_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    div_act != '0);
  a_r6_dr_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 4'd0 && rx_cnt == CW'(1) && !rx_push) |=> !lsr[0]);
endmodule

bind packed_uart packed_uart_chk #(.DEPTH(DEPTH), .DIV_W(DIV_W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .tx_o(tx_o), .tx_busy(tx_busy), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
  .rx_push(rx_push), .lsr(lsr), .div_act(div_act)
);

// File: tb/packed_uart_tb_top.sv
`timescale 1ns/1ps
module packed_uart_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [5:2] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic loop = 1'b1, rx_drv = 1'b1, tx_o, rx_i;
  int compared = 0, mismatched = 0;
  bit done = 0;

  always #4 clk = ~clk;
  assign rx_i = loop ? tx_o : rx_drv;

  packed_uart dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rx_i(rx_i), .tx_o(tx_o));

  // low-run recorder on the transmit line
  int runs [32];
  int nruns = 0, cur = 0;
  always @(negedge clk) begin
    if (rst_n && tx_o == 1'b0) cur++;
    else if (cur > 0) begin
      if (nruns < 32) runs[nruns] = cur;
      nruns++;
      cur = 0;
    end
  end

  // {divisor, character}
  localparam logic [15:0] VEC [6] = '{16'h0155, 16'h02A3, 16'h0300,
                                     16'h01F0, 16'h0081, 16'h053C};

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] idx, input logic [31:0] d);
    wr_en = 1'b1; addr = idx; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] idx, output logic [31:0] d);
    rd_en = 1'b1; addr = idx;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  logic [7:0] got [8];
  int ngot;
  task automatic collect(input int polls);
    logic [31:0] v;
    ngot = 0;
    for (int i = 0; i < polls; i++) begin
      bus_rd(4'd5, v);
      if (v[0]) begin
        bus_rd(4'd0, v);
        if (ngot < 8) got[ngot] = v[7:0];
        ngot++;
      end
    end
  endtask

  task automatic drive_frame(input logic [7:0] b, input logic stop, input int d);
    logic [9:0] f;
    f = {stop, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      rx_drv = f[i];
      repeat (16 * d) @(negedge clk);
    end
    rx_drv = 1'b1;
    repeat (40) @(negedge clk);
  endtask

  int exp_runs [12];
  int exp_n;
  task automatic calc_runs(input logic [7:0] b, input int d);
    logic [9:0] f;
    int r;
    f = {1'b1, b, 1'b0};
    exp_n = 0; r = 0;
    for (int i = 0; i < 10; i++) begin
      if (!f[i]) r++;
      else if (r > 0) begin exp_runs[exp_n] = r * 16 * d; exp_n++; r = 0; end
    end
  endtask

  initial begin
    repeat (1000) @(posedge clk);
    repeat (149000) @(posedge clk);
    if (!done) begin
      mismatched++; compared++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R2 reset state
    check("R2 tx idle", tx_o, 1);
    bus_rd(4'd5, v); check("R2 lsr", v, 32'h60);
    bus_rd(4'd9, v); check("R2 divisor", v, 1);
    bus_rd(4'd3, v); check("R2 char/fcr", v, 0);
    bus_rd(4'd4, v); check("R2 lcr/mcr", v, 32'h0300);
    // R1 packed register read-back
    bus_wr(4'd4, 32'hFFFF_1BC5); bus_rd(4'd4, v); check("R1 lcr/mcr", v, 32'h1BC5);
    bus_wr(4'd3, 32'h0000_AB00); bus_rd(4'd3, v); check("R1 char/fcr", v, 32'hAB00);
    bus_wr(4'd9, 32'd7); bus_rd(4'd9, v); check("R1 divisor", v, 7);

    // R3/R4/R6 vector walk in loopback
    foreach (VEC[k]) begin
      int d;
      d = (VEC[k][15:8] == 0) ? 1 : int'(VEC[k][15:8]);
      calc_runs(VEC[k][7:0], d);
      bus_wr(4'd9, 32'(VEC[k][15:8]));
      nruns = 0;
      bus_wr(4'd0, 32'(VEC[k][7:0]));
      for (int i = 0; i < 2000; i++) begin
        bus_rd(4'd5, v);
        if (v[6] && v[0]) break;
      end
      check("R6 data ready", v, 32'h61);
      bus_rd(4'd0, v); check("R6 rx char", v[7:0], VEC[k][7:0]);
      bus_rd(4'd5, v); check("R6 dr cleared", v, 32'h60);
      check("R3 low runs", nruns, exp_n);
      for (int i = 0; i < exp_n; i++) check("R3 R4 bit time", runs[i], exp_runs[i]);
    end

    // R8 holding-empty drops right after queueing
    bus_wr(4'd9, 1);
    bus_wr(4'd0, 32'h5A);
    bus_rd(4'd5, v); check("R8 thre/temt low", v, 32'h00);
    collect(300); check("R8 count", ngot, 1); check("R8 char", got[0], 8'h5A);
    bus_rd(4'd5, v); check("R8 idle lsr", v, 32'h60);

    // R9 FIFO disabled: third back-to-back write dropped
    bus_wr(4'd0, 32'h11); bus_wr(4'd0, 32'h22); bus_wr(4'd0, 32'h33);
    collect(600);
    check("R9 single count", ngot, 2);
    check("R9 single c0", got[0], 8'h11); check("R9 single c1", got[1], 8'h22);

    // R9 FIFO enabled: sixth write dropped
    bus_wr(4'd3, 32'h1);
    for (int i = 0; i < 6; i++) bus_wr(4'd0, 32'(8'hA0 + i));
    collect(1200);
    check("R9 fifo count", ngot, 5);
    for (int i = 0; i < 5; i++) check("R9 fifo order", got[i], 8'hA0 + i);

    // R5 divisor changed mid-frame applies to next frame
    nruns = 0;
    bus_wr(4'd0, 32'hFF); bus_wr(4'd0, 32'hFF); bus_wr(4'd9, 2);
    collect(900);
    check("R5 count", ngot, 2);
    check("R5 runs", nruns, 2);
    check("R5 old period", runs[0], 16);
    check("R5 new period", runs[1], 32);
    bus_wr(4'd9, 1);

    // R7 framing error via external line
    loop = 1'b0;
    drive_frame(8'hC3, 1'b0, 1);
    bus_rd(4'd5, v); check("R7 fe set", v, 32'h69);
    bus_rd(4'd5, v); check("R7 fe cleared by read", v, 32'h61);
    bus_rd(4'd0, v); check("R7 char kept", v[7:0], 8'hC3);

    // R10 receive path full, FIFO disabled
    bus_wr(4'd3, 32'h0);
    drive_frame(8'h4E, 1'b1, 1);
    drive_frame(8'h71, 1'b1, 1);
    bus_rd(4'd5, v); check("R10 one held", v, 32'h61);
    bus_rd(4'd0, v); check("R10 first kept", v[7:0], 8'h4E);
    bus_rd(4'd5, v); check("R10 second dropped", v, 32'h60);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule